// File: doc/BRIEF.md
# Oversampling Baud Generator with Majority Voting

This block sets the bit timing for a serial receiver and transmitter, and it decides the value of each received bit. A prescale counter divides the system clock. Its divide ratio is (prescale + 1), and each wrap gives one sample tick. A sample counter groups N sample ticks into one bit period, so one bit lasts N × (prescale + 1) clock cycles. Seen the other way, the baud rate is the clock frequency divided by N × (prescale + 1).

On each bit the block samples the synchronized receive line on three consecutive sample ticks around the middle of the bit. It then reports the majority of the three samples together with a one-cycle valid strobe. A bit-boundary tick and a mid-bit tick let the framing logic around the block (start detection, byte assembly, transmit shifting) follow the bit grid. An alignment pulse restarts the grid at a bit boundary when a new frame begins.

Top module: `ovs_baud_gen`

## Requirements
- R1: While reset is held and after it is released, `bit_tick_o`, `mid_tick_o` and `bit_valid_o` are low and `bit_o` is 1. The active timing is prescale 0 and 32 samples per bit. The first cycle after reset release is cycle 0 of a bit, so `bit_tick_o` first rises in cycle 31.
- R2: Number the cycles of a bit c = 0, 1, … from its first cycle, and let P be the active prescale. A sample tick occurs in every cycle where c mod (P+1) = P. Sample index s = floor(c/(P+1)). `bit_tick_o` is high for exactly one cycle per bit: the cycle of sample index N−1, which is the last cycle of the bit. The bit lasts N·(P+1) cycles.
- R3: A samples-per-bit input below 8, including 0, is treated as 8. Values from 8 to 63 are used as given.
- R4: Let M = floor(N/2). `mid_tick_o` is high only in the sample tick cycle of index M, which is cycle M·(P+1)+P of the bit.
- R5: The receive line is sampled at the sample ticks of index M−1, M and M+1. `bit_o` takes the majority of the three samples. `bit_valid_o` is high for exactly one cycle, the cycle after the index M+1 tick. `bit_o` holds its value until the next valid strobe.
- R6: A high `align_i` clears both counters, so the cycle after it is cycle 0 of a bit. It also loads the configuration inputs at once. A vote that completes in the same cycle as the alignment produces no valid strobe.
- R7: A change on the prescale or samples-per-bit inputs in the middle of a bit does not change that bit's timing. The new values take effect from the next bit boundary.
- R8: The receive line has no effect on `bit_o` in any cycle other than the three vote ticks of a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prescale_i | input | 12 | Prescale value P; sample ticks every P+1 clocks |
| cfg_spb_i | input | 6 | Samples per bit N (below 8 treated as 8) |
| align_i | input | 1 | Restart the bit grid at a boundary and load configuration |
| rx_i | input | 1 | Synchronized receive line |
| bit_tick_o | output | 1 | High in the last cycle of each bit |
| mid_tick_o | output | 1 | High on the middle sample tick of each bit |
| bit_o | output | 1 | Majority-voted received bit |
| bit_valid_o | output | 1 | One-cycle strobe marking a new `bit_o` |

## Verification
A wrong prescale or sample count moves the boundary and mid-bit ticks by whole sample periods. This shows at the ports in the first bit after alignment, within N·(P+1) cycles. A vote window shifted by one sample index changes `bit_o`, because the bench drives the inverse of the expected majority on every non-vote cycle. Any fault in the configuration latch timing appears in the first bit after a mid-bit change, as a boundary tick at the wrong cycle.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
    localparam int PRE_W   = 12;
    localparam int SPB_W   = 6;
    localparam int SPB_MIN = 8;
    localparam int SPB_DEF = 32;

    typedef logic [PRE_W-1:0] pre_t;
    typedef logic [SPB_W-1:0] spb_t;

    typedef struct packed {
        pre_t pre;
        spb_t n;
    } ovs_cfg_t;

    typedef struct packed {
        logic samp;
        logic bnd;
        logic mid;
        logic v_first;
        logic v_last;
    } ovs_tick_t;

    function automatic spb_t clamp_spb(input spb_t v);
        return (v < spb_t'(SPB_MIN)) ? spb_t'(SPB_MIN) : v;
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/ovs_cfg_hold.sv
module ovs_cfg_hold
    import ovs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  ovs_cfg_t cfg_raw,
    output ovs_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.pre <= '0;
            cfg_q.n   <= spb_t'(SPB_DEF);
        end else if (load) begin
            cfg_q.pre <= cfg_raw.pre;
            cfg_q.n   <= clamp_spb(cfg_raw.n);
        end
    end
endmodule

// File: rtl/ovs_prescaler.sv
module ovs_prescaler
    import ovs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  pre_t limit,
    output logic samp
);
    pre_t cnt;

    assign samp = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ovs_sample_ctr.sv
module ovs_sample_ctr
    import ovs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      samp,
    input  spb_t      n,
    output ovs_tick_t ticks
);
    spb_t scnt;
    spb_t half;
    spb_t last;

    assign half = n >> 1;
    assign last = n - 1'b1;

    always_comb begin
        ticks.samp    = samp;
        ticks.bnd     = samp && (scnt == last);
        ticks.mid     = samp && (scnt == half);
        ticks.v_first = samp && (scnt == half - 1'b1);
        ticks.v_last  = samp && (scnt == half + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            scnt <= '0;
        end else if (samp) begin
            scnt <= (scnt == last) ? '0 : scnt + 1'b1;
        end
    end
endmodule

// File: rtl/ovs_voter.sv
module ovs_voter
    import ovs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  ovs_tick_t ticks,
    input  logic      rx,
    output logic      bit_q,
    output logic      valid_q
);
    logic s_first;
    logic s_mid;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_first <= 1'b0;
            s_mid   <= 1'b0;
            bit_q   <= 1'b1;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (!clr) begin
                if (ticks.v_first) s_first <= rx;
                if (ticks.mid)     s_mid   <= rx;
                if (ticks.v_last) begin
                    bit_q   <= maj3(s_first, s_mid, rx);
                    valid_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ovs_baud_gen.sv
module ovs_baud_gen
    import ovs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] cfg_prescale_i,
    input  logic [5:0]  cfg_spb_i,
    input  logic        align_i,
    input  logic        rx_i,
    output logic        bit_tick_o,
    output logic        mid_tick_o,
    output logic        bit_o,
    output logic        bit_valid_o
);
    ovs_cfg_t  cfg_raw;
    ovs_cfg_t  act_cfg;
    ovs_tick_t ticks;
    logic      samp;
    logic      cfg_load;

    assign cfg_raw.pre = cfg_prescale_i;
    assign cfg_raw.n   = cfg_spb_i;
    assign cfg_load    = align_i | ticks.bnd;

    ovs_cfg_hold u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .cfg_raw (cfg_raw),
        .cfg_q   (act_cfg)
    );

    ovs_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (align_i),
        .limit (act_cfg.pre),
        .samp  (samp)
    );

    ovs_sample_ctr u_sctr (
        .clk   (clk),
        .rst   (rst),
        .clr   (align_i),
        .samp  (samp),
        .n     (act_cfg.n),
        .ticks (ticks)
    );

    ovs_voter u_vote (
        .clk     (clk),
        .rst     (rst),
        .clr     (align_i),
        .ticks   (ticks),
        .rx      (rx_i),
        .bit_q   (bit_o),
        .valid_q (bit_valid_o)
    );

    assign bit_tick_o = ticks.bnd;
    assign mid_tick_o = ticks.mid;
endmodule

// File: rtl/ovs_baud_gen_chk.sv
module ovs_baud_gen_chk
    import ovs_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     align_i,
    input logic     bit_tick_o,
    input logic     mid_tick_o,
    input logic     bit_valid_o,
    input ovs_cfg_t act_cfg
);
    // R3: the active sample count never drops below the minimum
    a_r3_spb_floor: assert property (@(posedge clk) disable iff (rst)
        act_cfg.n >= spb_t'(SPB_MIN));

    // R7: active timing only moves at a boundary or an alignment
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (!bit_tick_o && !align_i) |=> ($stable(act_cfg.pre) && $stable(act_cfg.n)));

    // R5: the valid strobe lasts a single cycle
    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        bit_valid_o |=> !bit_valid_o);

    // R6: alignment cancels any vote finishing in the same cycle
    a_r6_align_no_valid: assert property (@(posedge clk) disable iff (rst)
        align_i |=> !bit_valid_o);

    // R4: the middle tick never coincides with the boundary tick
    a_r4_mid_not_bnd: assert property (@(posedge clk) disable iff (rst)
        mid_tick_o |-> !bit_tick_o);

    // R2: boundary ticks never come back to back
    a_r2_bnd_spaced: assert property (@(posedge clk) disable iff (rst)
        bit_tick_o |=> !bit_tick_o);
endmodule

bind ovs_baud_gen ovs_baud_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .align_i     (align_i),
    .bit_tick_o  (bit_tick_o),
    .mid_tick_o  (mid_tick_o),
    .bit_valid_o (bit_valid_o),
    .act_cfg     (act_cfg)
);

// File: tb/ovs_baud_gen_bench.sv
module ovs_baud_gen_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] cfg_prescale_i;
    logic [5:0]  cfg_spb_i;
    logic        align_i;
    logic        rx_i;
    logic        bit_tick_o;
    logic        mid_tick_o;
    logic        bit_o;
    logic        bit_valid_o;

    int n_cmp  = 0;
    int n_bad  = 0;
    int patt   = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ovs_baud_gen u_ovs_baud_gen (
        .clk            (clk),
        .rst            (rst),
        .cfg_prescale_i (cfg_prescale_i),
        .cfg_spb_i      (cfg_spb_i),
        .align_i        (align_i),
        .rx_i           (rx_i),
        .bit_tick_o     (bit_tick_o),
        .mid_tick_o     (mid_tick_o),
        .bit_o          (bit_o),
        .bit_valid_o    (bit_valid_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    function automatic int eff_n(input int spb);
        return (spb < 8) ? 8 : spb;
    endfunction

    task automatic do_align();
        align_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        align_i = 1'b0;
    endtask

    // Runs nbits bits starting at cycle 0, checking every cycle.
    task automatic run_bits(input int p, input int n, input int nbits,
                            input bit chg, input int np, input int ns);
        int m = n / 2;
        for (int b = 0; b < nbits; b++) begin
            logic [2:0] code = 3'(patt);
            logic       mj   = (code[0] & code[1]) | (code[0] & code[2]) | (code[1] & code[2]);
            patt++;
            for (int c = 0; c < n * (p + 1); c++) begin
                int  s    = c / (p + 1);
                bit  samp = ((c % (p + 1)) == p);
                // R8: every non-vote cycle carries the inverse of the majority
                if (samp && s == m - 1)      rx_i = code[0];
                else if (samp && s == m)     rx_i = code[1];
                else if (samp && s == m + 1) rx_i = code[2];
                else                         rx_i = ~mj;
                check("R2 bit_tick", bit_tick_o, samp && (s == n - 1));
                check("R4 mid_tick", mid_tick_o, samp && (s == m));
                check("R5 bit_valid", bit_valid_o, c == (m + 1) * (p + 1) + p + 1);
                if (c == (m + 1) * (p + 1) + p + 1)
                    check("R5 bit_o majority", bit_o, mj);
                if (c == (m + 1) * (p + 1) + p + 2)
                    check("R5 bit_o hold", bit_o, mj);
                if (chg && b == 0 && c == 1) begin
                    // R7: mid-bit change must wait for the boundary
                    cfg_prescale_i = 12'(np);
                    cfg_spb_i      = 6'(ns);
                end
                @(posedge clk);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        int spb_list [9] = '{0, 3, 7, 8, 9, 12, 17, 32, 63};
        rst = 1'b1; align_i = 1'b0; rx_i = 1'b1;
        cfg_prescale_i = 12'd0; cfg_spb_i = 6'd32;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset bit_tick", bit_tick_o, 1'b0);
        check("R1 reset mid_tick", mid_tick_o, 1'b0);
        check("R1 reset valid", bit_valid_o, 1'b0);
        check("R1 reset bit_o", bit_o, 1'b1);
        // R1: defaults are prescale 0, 32 samples; inputs held at something else
        cfg_prescale_i = 12'd2; cfg_spb_i = 6'd9;
        rst = 1'b0;
        run_bits(0, 32, 1, 1'b0, 0, 0);
        // after first boundary the inputs apply
        run_bits(2, 9, 1, 1'b0, 0, 0);

        // R2, R3, R4, R5, R6: sweep of prescale and samples per bit
        for (int p = 0; p < 4; p++) begin
            foreach (spb_list[i]) begin
                cfg_prescale_i = 12'(p);
                cfg_spb_i      = 6'(spb_list[i]);
                repeat (5) begin
                    @(posedge clk);
                    @(negedge clk);
                end
                do_align();
                run_bits(p, eff_n(spb_list[i]), 3, 1'b0, 0, 0);
            end
        end

        // R7: change configuration mid-bit
        cfg_prescale_i = 12'd1; cfg_spb_i = 6'd8;
        do_align();
        run_bits(1, 8, 1, 1'b1, 0, 10);
        run_bits(0, 10, 2, 1'b0, 0, 0);

        // R6: alignment in the cycle the last vote is taken
        cfg_prescale_i = 12'd2; cfg_spb_i = 6'd10;
        do_align();
        for (int c = 0; c < 20; c++) begin
            @(posedge clk);
            @(negedge clk);
        end
        do_align();
        check("R6 align cancels vote", bit_valid_o, 1'b0);
        run_bits(2, 10, 1, 1'b0, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule